// File: doc/BRIEF.md
# GPIO Ports with Alternate-Function Override

This block provides four 16-bit general-purpose I/O ports, 64 pins in all, behind a small synchronous register bus. Each port has three registers. The output latch holds the value driven while the pin is under GPIO control. The direction register holds the output-enable bit for each pin. The pin-read register returns the synchronized pin level. A single shared configuration register hands whole groups of pins to alternate peripheral functions. Those peripherals supply their own output value and enable as plain 64-bit input vectors.

For every pin, the block chooses one of two sources for the output value and the output enable: the GPIO registers or the peripheral. The choice is made per pin, from the configuration register. A debug-mode input can also force the two serial-link pins onto their peripheral. The GPIO registers keep accepting writes while a pin is owned by a peripheral, so firmware can prepare a state that takes effect when the pin is handed back. Pin `p*16+b` is port `p`, bit `b`.

Top module: `gpio_altfn_ports`

## Requirements
- R1: Synchronous active-high reset clears every output latch, every direction register and the configuration register. After reset, `pin_oe` is all zero whatever `af_oe` holds.
- R2: The register map decodes as follows. Offsets 0x00–0x03 are the output latches of ports 0–3. Offsets 0x04–0x07 are the direction registers of ports 0–3. Offset 0x08 is the configuration register. Offsets 0x10–0x13 are the pin-read registers of ports 0–3. A write takes effect at the clock edge where `reg_we` is high, and `reg_rdata` reflects `reg_addr` combinationally.
- R3: Reading an output latch or a direction register returns the last value written, whatever the pin directions or the configuration.
- R4: For a pin not owned by a peripheral, `pin_oe` equals its direction bit (1 = output) and `pin_out` equals its output-latch bit.
- R5: For a pin owned by a peripheral, `pin_oe` and `pin_out` follow `af_oe` and `af_out` for that pin. Writes to the GPIO registers still update them, and the written values drive the pin once ownership is released.
- R6: Configuration bits map to pins (flat pin index) as follows:
  - bit 0 owns pins 0–23 and 33–36;
  - bit 1 owns pins 24–32;
  - bits 2–6 each own one pin, 37–41 in order;
  - bit 7 owns pins 42–45 and 48–55;
  - bit 8 owns pin 56 and bit 9 owns pin 57;
  - bit 10 owns pin 58 and bit 11 owns pin 59;
  - bit 12 owns pin 46 and bit 13 owns pin 47;
  - bit 14 owns pin 63;
  - bit 15 and pins 60–62 have no alternate.
- R7: A pin-read register returns `pin_in` after a two-flop synchronizer, whatever the configuration. A level change is readable after the second rising edge and not after the first.
- R8: While `dbg_mode` is high, pins 58 and 59 are owned by their peripheral whatever configuration bits 10 and 11 hold.
- R9: A write to an unmapped offset, or to a pin-read offset, changes no register. A read from an unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dbg_mode | input | 1 | Forces the serial-link pins to their peripheral |
| reg_addr | input | 5 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| pin_in | input | 64 | Pad input levels |
| af_out | input | 64 | Peripheral output values |
| af_oe | input | 64 | Peripheral output enables |
| pin_out | output | 64 | Pad output values |
| pin_oe | output | 64 | Pad output enables |

## Verification
On every cycle, the assertions check the following:
- reset clearing;
- register updates at the decoded offsets;
- stability of all registers after writes to unmapped offsets;
- the two-cycle synchronizer delay;
- the GPIO drive when no group is selected;
- peripheral ownership of the group selected by configuration bit 0;
- the debug override of pins 58 and 59.

The rest of the group-to-pin map, the latency edge at exactly one cycle, and the fact that writes made during peripheral ownership reappear after release can only be shown by the bench's scenarios.

// File: rtl/gpio_altfn_pkg.sv
package gpio_altfn_pkg;

    localparam int NPORT = 4;
    localparam int PW    = 16;
    localparam int NPIN  = NPORT * PW;
    localparam int AW    = 5;
    localparam int CFGW  = 16;
    localparam int PSELW = $clog2(NPORT);

    localparam logic [AW-1:0] OFS_CFG = 5'h08;
    localparam int PIN_SER_IN  = 58;
    localparam int PIN_SER_OUT = 59;

    typedef struct packed {
        logic             hit_lat;
        logic             hit_dir;
        logic             hit_cfg;
        logic             hit_pin;
        logic [PSELW-1:0] port;
    } regsel_t;

    function automatic regsel_t decode_ofs(logic [AW-1:0] a);
        regsel_t s;
        s.port    = a[PSELW-1:0];
        s.hit_lat = (a[AW-1:2] == 3'b000);
        s.hit_dir = (a[AW-1:2] == 3'b001);
        s.hit_cfg = (a == OFS_CFG);
        s.hit_pin = (a[AW-1:2] == 3'b100);
        return s;
    endfunction

    // Pins claimed by one configuration bit.
    function automatic logic [NPIN-1:0] group_pins(int g);
        logic [NPIN-1:0] m;
        m = '0;
        case (g)
            0: begin
                m[23:0]  = '1;
                m[36:33] = '1;
            end
            1: m[32:24] = '1;
            2, 3, 4, 5, 6: m[35+g] = 1'b1;
            7: begin
                m[45:42] = '1;
                m[55:48] = '1;
            end
            8:  m[56] = 1'b1;
            9:  m[57] = 1'b1;
            10: m[58] = 1'b1;
            11: m[59] = 1'b1;
            12: m[46] = 1'b1;
            13: m[47] = 1'b1;
            14: m[63] = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [NPIN-1:0] owned_pins(logic [CFGW-1:0] cfg, logic dbg);
        logic [NPIN-1:0] m;
        m = '0;
        for (int g = 0; g < CFGW; g++)
            if (cfg[g]) m = m | group_pins(g);
        if (dbg) begin
            m[PIN_SER_IN]  = 1'b1;
            m[PIN_SER_OUT] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_altfn_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   reg_addr,
    input  logic [PW-1:0]   reg_wdata,
    input  logic            reg_we,
    input  logic [NPIN-1:0] pin_sync,
    output logic [PW-1:0]   reg_rdata,
    output logic [NPIN-1:0] lat_flat,
    output logic [NPIN-1:0] dir_flat,
    output logic [CFGW-1:0] cfg_q
);
    logic [PW-1:0] lat_q [NPORT];
    logic [PW-1:0] dir_q [NPORT];
    regsel_t       sel;

    assign sel = decode_ofs(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPORT; p++) begin
                lat_q[p] <= '0;
                dir_q[p] <= '0;
            end
            cfg_q <= '0;
        end else if (reg_we) begin
            if (sel.hit_lat) lat_q[sel.port] <= reg_wdata;
            if (sel.hit_dir) dir_q[sel.port] <= reg_wdata;
            if (sel.hit_cfg) cfg_q           <= reg_wdata;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_flat
        assign lat_flat[p*PW +: PW] = lat_q[p];
        assign dir_flat[p*PW +: PW] = dir_q[p];
    end

    always_comb begin
        reg_rdata = '0;
        if (sel.hit_lat) reg_rdata = lat_q[sel.port];
        if (sel.hit_dir) reg_rdata = dir_q[sel.port];
        if (sel.hit_cfg) reg_rdata = cfg_q;
        if (sel.hit_pin) reg_rdata = pin_sync[sel.port*PW +: PW];
    end

    logic unmapped;
    assign unmapped = !(sel.hit_lat || sel.hit_dir || sel.hit_cfg || sel.hit_pin);

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (cfg_q == '0 && dir_flat == '0 && lat_flat == '0));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && sel.hit_dir) |=> dir_q[$past(sel.port)] == $past(reg_wdata));

    // R3
    lat_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && sel.hit_lat) |=> lat_q[$past(sel.port)] == $past(reg_wdata));

    // R9
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && (unmapped || sel.hit_pin)) |=>
            ($stable(cfg_q) && $stable(lat_flat) && $stable(dir_flat)));

    // R9
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> reg_rdata == '0);

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync
    import gpio_altfn_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_sync
);
    logic [NPIN-1:0] meta_q;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[p*PW +: PW]   <= '0;
                pin_sync[p*PW +: PW] <= '0;
            end else begin
                meta_q[p*PW +: PW]   <= pin_in[p*PW +: PW];
                pin_sync[p*PW +: PW] <= meta_q[p*PW +: PW];
            end
        end
    end

    // R7
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> pin_sync == $past(pin_in, 2));

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_altfn_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            dbg_mode,
    input  logic [CFGW-1:0] cfg_q,
    input  logic [NPIN-1:0] lat_flat,
    input  logic [NPIN-1:0] dir_flat,
    input  logic [NPIN-1:0] af_out,
    input  logic [NPIN-1:0] af_oe,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe
);
    logic [NPIN-1:0] owned;

    assign owned = owned_pins(cfg_q, dbg_mode);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        for (genvar b = 0; b < PW; b++) begin : g_bit
            localparam int I = p*PW + b;
            assign pin_oe[I]  = owned[I] ? af_oe[I]  : dir_flat[I];
            assign pin_out[I] = owned[I] ? af_out[I] : lat_flat[I];
        end
    end

    // R8
    dbg_serial_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_mode |-> (pin_oe[PIN_SER_IN]   == af_oe[PIN_SER_IN]   &&
                      pin_oe[PIN_SER_OUT]  == af_oe[PIN_SER_OUT]  &&
                      pin_out[PIN_SER_IN]  == af_out[PIN_SER_IN]  &&
                      pin_out[PIN_SER_OUT] == af_out[PIN_SER_OUT]));

endmodule

// File: rtl/gpio_altfn_ports.sv
module gpio_altfn_ports
    import gpio_altfn_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            dbg_mode,
    input  logic [AW-1:0]   reg_addr,
    input  logic [PW-1:0]   reg_wdata,
    input  logic            reg_we,
    output logic [PW-1:0]   reg_rdata,
    input  logic [NPIN-1:0] pin_in,
    input  logic [NPIN-1:0] af_out,
    input  logic [NPIN-1:0] af_oe,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe
);
    logic [NPIN-1:0] pin_sync;
    logic [NPIN-1:0] lat_flat;
    logic [NPIN-1:0] dir_flat;
    logic [CFGW-1:0] cfg_q;

    gpio_pin_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .pin_sync (pin_sync)
    );

    gpio_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .pin_sync  (pin_sync),
        .reg_rdata (reg_rdata),
        .lat_flat  (lat_flat),
        .dir_flat  (dir_flat),
        .cfg_q     (cfg_q)
    );

    gpio_pad_mux u_mux (
        .clk      (clk),
        .rst      (rst),
        .dbg_mode (dbg_mode),
        .cfg_q    (cfg_q),
        .lat_flat (lat_flat),
        .dir_flat (dir_flat),
        .af_out   (af_out),
        .af_oe    (af_oe),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    // R4
    gpio_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q == '0 && !dbg_mode) |-> (pin_oe == dir_flat && pin_out == lat_flat));

    // R6
    ram_group_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_q[0] |-> (pin_oe[23:0] == af_oe[23:0] && pin_out[36:33] == af_out[36:33]));

endmodule

// File: tb/sim_gpio_altfn_ports.sv
module sim_gpio_altfn_ports;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dbg_mode = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_rdata;
    logic [63:0] pin_in = '0;
    logic [63:0] af_out = '0;
    logic [63:0] af_oe = '1;
    logic [63:0] pin_out;
    logic [63:0] pin_oe;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #10 clk = ~clk;

    gpio_altfn_ports u0 (
        .clk(clk), .rst(rst), .dbg_mode(dbg_mode),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .pin_in(pin_in), .af_out(af_out),
        .af_oe(af_oe), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // {offset, write data, expected read-back}
    localparam logic [36:0] TBL [16] = '{
        {5'h00, 16'hA5A5, 16'hA5A5}, {5'h01, 16'h1234, 16'h1234},
        {5'h02, 16'hFFFF, 16'hFFFF}, {5'h03, 16'h0F0F, 16'h0F0F},
        {5'h04, 16'h00FF, 16'h00FF}, {5'h05, 16'hFF00, 16'hFF00},
        {5'h06, 16'h8001, 16'h8001}, {5'h07, 16'h7FFE, 16'h7FFE},
        {5'h08, 16'h0000, 16'h0000}, {5'h09, 16'hBEEF, 16'h0000},
        {5'h0F, 16'h1111, 16'h0000}, {5'h14, 16'h2222, 16'h0000},
        {5'h1F, 16'h3333, 16'h0000}, {5'h10, 16'hFFFF, 16'hC3C3},
        {5'h13, 16'h0000, 16'h9876}, {5'h0C, 16'h4444, 16'h0000}
    };

    // {configuration value, owned-pin mask}
    localparam logic [79:0] GRP [7] = '{
        {16'h0001, 64'h0000_001E_00FF_FFFF},
        {16'h0002, 64'h0000_0001_FF00_0000},
        {16'h0080, 64'h00FF_3C00_0000_0000},
        {16'h0008, 64'h0000_0040_0000_0000},
        {16'h4000, 64'h8000_0000_0000_0000},
        {16'h0C00, 64'h0C00_0000_0000_0000},
        {16'h3300, 64'h0300_C000_0000_0000}
    };

    logic [63:0] dir_m, lat_m;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [63:0] exp_oe(logic [63:0] m);
        return (af_oe & m) | (dir_m & ~m);
    endfunction

    function automatic logic [63:0] exp_out(logic [63:0] m);
        return (af_out & m) | (lat_m & ~m);
    endfunction

    initial begin
        logic [15:0] d;
        pin_in = 64'h9876_5432_ABCD_C3C3;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        for (int p = 0; p < 4; p++) begin
            rd(5'(4 + p), d); chk("R1 direction after reset", 64'(d), 64'h0);
        end
        rd(5'h08, d); chk("R1 configuration after reset", 64'(d), 64'h0);
        chk("R1 pin_oe after reset", pin_oe, 64'h0);

        // Table of write / read-back vectors
        for (int i = 0; i < 16; i++) begin
            wr(TBL[i][36:32], TBL[i][31:16]);
            rd(TBL[i][36:32], d);
            chk("R2 R3 R9 table read-back", 64'(d), 64'(TBL[i][15:0]));
        end
        rd(5'h00, d); chk("R9 latch 0 untouched by unmapped writes", 64'(d), 64'hA5A5);
        rd(5'h03, d); chk("R9 latch 3 untouched by pin-read write", 64'(d), 64'h0F0F);
        rd(5'h08, d); chk("R9 configuration untouched", 64'(d), 64'h0);
        rd(5'h07, d); chk("R9 direction 3 untouched", 64'(d), 64'h7FFE);

        dir_m = 64'h7FFE_8001_FF00_00FF;
        lat_m = 64'h0F0F_FFFF_1234_A5A5;
        af_oe  = 64'hF0F0_F0F0_F0F0_F0F0;
        af_out = 64'h3C3C_3C3C_3C3C_3C3C;
        #1;
        chk("R4 GPIO output enable", pin_oe, dir_m);
        chk("R4 GPIO output value", pin_out, lat_m);

        // Group ownership
        for (int i = 0; i < 7; i++) begin
            wr(5'h08, GRP[i][79:64]);
            #1;
            chk("R6 group output enable", pin_oe, exp_oe(GRP[i][63:0]));
            chk("R6 group output value", pin_out, exp_out(GRP[i][63:0]));
        end

        // Writes while owned, then release
        wr(5'h08, 16'h0001);
        wr(5'h00, 16'h0000);
        wr(5'h04, 16'hFFFF);
        lat_m[15:0] = 16'h0000;
        dir_m[15:0] = 16'hFFFF;
        rd(5'h00, d); chk("R3 latch read-back while owned", 64'(d), 64'h0);
        chk("R5 owned pins follow peripheral", pin_out, exp_out(64'h0000_001E_00FF_FFFF));
        chk("R5 owned enables follow peripheral", pin_oe, exp_oe(64'h0000_001E_00FF_FFFF));
        wr(5'h08, 16'h0000);
        #1;
        chk("R5 released value from latch", pin_out, lat_m);
        chk("R5 released enable from direction", pin_oe, dir_m);

        // Synchronizer latency and readback under full ownership
        wr(5'h08, 16'hFFFF);
        @(negedge clk);
        pin_in[47:32] = 16'h5AA5;
        @(negedge clk);
        rd(5'h12, d); chk("R7 not visible after one edge", 64'(d), 64'h5432);
        @(negedge clk);
        rd(5'h12, d); chk("R7 visible after two edges", 64'(d), 64'h5AA5);
        rd(5'h11, d); chk("R7 owned pin readback", 64'(d), 64'hABCD);

        // Debug override
        wr(5'h08, 16'h0000);
        @(negedge clk);
        dbg_mode = 1'b1;
        #1;
        chk("R8 debug output enable", pin_oe, exp_oe(64'h0C00_0000_0000_0000));
        chk("R8 debug output value", pin_out, exp_out(64'h0C00_0000_0000_0000));
        wr(5'h08, 16'h0001);
        #1;
        chk("R8 debug plus group enable", pin_oe, exp_oe(64'h0C00_001E_00FF_FFFF));
        dbg_mode = 1'b0;
        #1;
        chk("R8 debug released", pin_oe, exp_oe(64'h0000_001E_00FF_FFFF));

        // Reset again with registers loaded
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(5'h00, d); chk("R1 latch cleared by reset", 64'(d), 64'h0);
        chk("R1 pin_oe cleared by reset", pin_oe, 64'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1-all actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule